// File: doc/BRIEF.md
# Bus Turnaround Wait Inserter

This block works beside the access sequencer of a static memory controller and decides, after every read, how many idle cycles must pass before the next access may drive the shared data bus. A slow device keeps driving the bus for a programmable number of cycles after its read strobe falls (the float time). The block records that time when a read finishes. It counts it down once per clock, and holds `start_ok` low only while a pending request would collide with it.

Each chip select has four settings: a float cycle count, an optimization enable, a read hold length and a write setup length. The read's own hold phase always absorbs part of the float time. When the reading chip select has optimization enabled, the setup phase of a following write absorbs more. A write issued in the cycle right after a read also gets one turnaround cycle. A read that follows a read on the same chip select is never stalled.

The sequencer raises `req_valid` with the target chip select and direction. An access starts on a clock edge where `req_valid` and `start_ok` are both high. The sequencer pulses `acc_end` in the last cycle of each access.

Top module: `bus_turnaround_gate`

## Requirements
- R1: After reset the float counter is clear, and the first request starts without a stall.
- R2: When a read ends, the float time left is the float count minus the read hold length, floored at zero. A hold at least as long as the float count leaves nothing.
- R3: With optimization disabled on the reading chip select, a write waits out the whole remaining float time. The write's setup length gives no credit.
- R4: With optimization enabled on the reading chip select, the write setup length of the requested chip select is subtracted from the remaining float time. When setup covers it, there is no float stall.
- R5: A read on a different chip select waits out the whole remaining float time, with no setup credit.
- R6: A read on the same chip select as the previous read is never stalled.
- R7: A write requested in the first cycle after a read ends is stalled for at least one turnaround cycle.
- R8: A chip select with float count 0 adds no float stall.
- R9: The remaining float time drops by one every clock. A request that appears after g idle cycles stalls g cycles fewer, and a request after the counter has drained is not stalled.
- R10: The end of a write access starts no float period, so the access after it is not stalled.
- R11: `start_ok` is high whenever `req_valid` is low.
- R12: Float count, hold length and optimization enable are taken from the chip select that did the read, not the one being requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Sequencer has an access pending |
| req_cs | input | CS_W (3) | Chip select of the pending access |
| req_is_write | input | 1 | Pending access is a write |
| acc_end | input | 1 | Last cycle of the access in progress |
| cfg_float | input | NUM_CS*FLOAT_W (32) | Float cycle count per chip select, 4 bits each, chip select 0 in the low bits |
| cfg_opt_en | input | NUM_CS (8) | Setup-overlap optimization enable per chip select |
| cfg_rd_hold | input | NUM_CS*CYC_W (32) | Read hold length per chip select |
| cfg_wr_setup | input | NUM_CS*CYC_W (32) | Write setup length per chip select |
| start_ok | output | 1 | Pending access may start on the next edge |

## Verification
The bench pairs a read with a following access and varies the chip selects, the direction, the optimization setting and the idle gap. It checks the exact number of stall cycles. A design that takes the setup credit from the reading chip select, or the optimization bit from the requested one, gives the wrong counts in the mixed chip select pairs. A design that drops the same-chip-select read exemption stalls reads that should start at once. A missing turnaround cycle shows up where hold or setup fully covers the float time, because the expected stall there is exactly one cycle. Cases with a hold longer than the float count, a zero float count and a write-only sequence check that no stray stall appears.

// File: rtl/bus_turnaround_pkg.sv
package bus_turnaround_pkg;

    localparam int FLOAT_W = 4;
    localparam int CYC_W   = 4;
    localparam int SUM_W   = ((FLOAT_W > CYC_W) ? FLOAT_W : CYC_W) + 1;

    typedef logic [FLOAT_W-1:0] float_t;
    typedef logic [CYC_W-1:0]   cyc_t;

    typedef struct packed {
        float_t float_cnt;
        logic   opt_en;
        cyc_t   rd_hold;
        cyc_t   wr_setup;
    } cs_cfg_t;

    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } acc_kind_t;

    // Float time not absorbed by a given number of overlapping cycles.
    function automatic float_t uncovered(input float_t fl, input cyc_t cyc);
        logic [SUM_W-1:0] a;
        logic [SUM_W-1:0] b;
        a = SUM_W'(fl);
        b = SUM_W'(cyc);
        return (a > b) ? FLOAT_W'(a - b) : '0;
    endfunction

    function automatic logic exceeds(input float_t fl, input cyc_t cyc);
        return SUM_W'(fl) > SUM_W'(cyc);
    endfunction

endpackage

// File: rtl/bus_turnaround_cfg_bank.sv
module bus_turnaround_cfg_bank
    import bus_turnaround_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [NUM_CS*FLOAT_W-1:0] cfg_float,
    input  logic [NUM_CS-1:0]         cfg_opt_en,
    input  logic [NUM_CS*CYC_W-1:0]   cfg_rd_hold,
    input  logic [NUM_CS*CYC_W-1:0]   cfg_wr_setup,
    input  logic [CS_W-1:0]           sel_rd,
    input  logic [CS_W-1:0]           sel_req,
    output cs_cfg_t                   rd_cfg,
    output cs_cfg_t                   req_cfg
);

    cs_cfg_t bank [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
        assign bank[i].float_cnt = cfg_float[i*FLOAT_W +: FLOAT_W];
        assign bank[i].opt_en    = cfg_opt_en[i];
        assign bank[i].rd_hold   = cfg_rd_hold[i*CYC_W +: CYC_W];
        assign bank[i].wr_setup  = cfg_wr_setup[i*CYC_W +: CYC_W];
    end

    always_comb begin
        rd_cfg  = bank[0];
        req_cfg = bank[0];
        for (int k = 0; k < NUM_CS; k++) begin
            if (CS_W'(k) == sel_rd)  rd_cfg  = bank[k];
            if (CS_W'(k) == sel_req) req_cfg = bank[k];
        end
    end

endmodule

// File: rtl/bus_turnaround_tracker.sv
module bus_turnaround_tracker
    import bus_turnaround_pkg::*;
#(
    parameter int CS_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic [CS_W-1:0] req_cs,
    input  logic            req_is_write,
    input  logic            acc_end,
    input  cs_cfg_t         cur_cfg,
    output logic [CS_W-1:0] cur_cs,
    output acc_kind_t       cur_kind,
    output float_t          float_cnt,
    output logic [CS_W-1:0] last_rd_cs,
    output logic            last_rd_opt,
    output logic            turn_pend
);

    logic read_done;
    assign read_done = acc_end && (cur_kind == ACC_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cs      <= '0;
            cur_kind    <= ACC_WRITE;
            float_cnt   <= '0;
            last_rd_cs  <= '0;
            last_rd_opt <= 1'b0;
            turn_pend   <= 1'b0;
        end else begin
            turn_pend <= 1'b0;
            if (read_done) begin
                float_cnt   <= uncovered(cur_cfg.float_cnt, cur_cfg.rd_hold);
                last_rd_cs  <= cur_cs;
                last_rd_opt <= cur_cfg.opt_en;
                turn_pend   <= 1'b1;
            end else if (float_cnt != '0) begin
                float_cnt <= float_cnt - 1'b1;
            end
            if (accept) begin
                cur_cs   <= req_cs;
                cur_kind <= req_is_write ? ACC_WRITE : ACC_READ;
            end
        end
    end

endmodule

// File: rtl/bus_turnaround_judge.sv
module bus_turnaround_judge
    import bus_turnaround_pkg::*;
#(
    parameter int CS_W = 3
) (
    input  logic            req_valid,
    input  logic [CS_W-1:0] req_cs,
    input  logic            req_is_write,
    input  float_t          float_cnt,
    input  logic [CS_W-1:0] last_rd_cs,
    input  logic            last_rd_opt,
    input  logic            turn_pend,
    input  cyc_t            next_setup,
    output logic            start_ok
);

    logic applies;
    cyc_t credit;
    logic float_stall;
    logic turn_stall;

    always_comb begin
        applies     = (float_cnt != '0) && (req_is_write || (req_cs != last_rd_cs));
        credit      = (last_rd_opt && req_is_write) ? next_setup : '0;
        float_stall = applies && exceeds(float_cnt, credit);
        turn_stall  = turn_pend && req_is_write;
        start_ok    = !(req_valid && (float_stall || turn_stall));
    end

endmodule

// File: rtl/bus_turnaround_gate.sv
module bus_turnaround_gate
    import bus_turnaround_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [CS_W-1:0]           req_cs,
    input  logic                      req_is_write,
    input  logic                      acc_end,
    input  logic [NUM_CS*FLOAT_W-1:0] cfg_float,
    input  logic [NUM_CS-1:0]         cfg_opt_en,
    input  logic [NUM_CS*CYC_W-1:0]   cfg_rd_hold,
    input  logic [NUM_CS*CYC_W-1:0]   cfg_wr_setup,
    output logic                      start_ok
);

    cs_cfg_t         cur_cfg;
    cs_cfg_t         req_cfg;
    logic [CS_W-1:0] cur_cs;
    acc_kind_t       cur_kind;
    float_t          float_cnt;
    logic [CS_W-1:0] last_rd_cs;
    logic            last_rd_opt;
    logic            turn_pend;
    logic            accept;
    logic            cur_is_read;
    float_t          sel_float;

    assign accept      = req_valid && start_ok;
    assign cur_is_read = (cur_kind == ACC_READ);
    assign sel_float   = cur_cfg.float_cnt;

    bus_turnaround_cfg_bank #(.NUM_CS(NUM_CS)) u_cfg (
        .cfg_float    (cfg_float),
        .cfg_opt_en   (cfg_opt_en),
        .cfg_rd_hold  (cfg_rd_hold),
        .cfg_wr_setup (cfg_wr_setup),
        .sel_rd       (cur_cs),
        .sel_req      (req_cs),
        .rd_cfg       (cur_cfg),
        .req_cfg      (req_cfg)
    );

    bus_turnaround_tracker #(.CS_W(CS_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .req_cs       (req_cs),
        .req_is_write (req_is_write),
        .acc_end      (acc_end),
        .cur_cfg      (cur_cfg),
        .cur_cs       (cur_cs),
        .cur_kind     (cur_kind),
        .float_cnt    (float_cnt),
        .last_rd_cs   (last_rd_cs),
        .last_rd_opt  (last_rd_opt),
        .turn_pend    (turn_pend)
    );

    bus_turnaround_judge #(.CS_W(CS_W)) u_judge (
        .req_valid    (req_valid),
        .req_cs       (req_cs),
        .req_is_write (req_is_write),
        .float_cnt    (float_cnt),
        .last_rd_cs   (last_rd_cs),
        .last_rd_opt  (last_rd_opt),
        .turn_pend    (turn_pend),
        .next_setup   (req_cfg.wr_setup),
        .start_ok     (start_ok)
    );

endmodule

// File: rtl/bus_turnaround_gate_chk.sv
module bus_turnaround_gate_chk
    import bus_turnaround_pkg::*;
#(
    parameter int CS_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [CS_W-1:0] req_cs,
    input logic            req_is_write,
    input logic            acc_end,
    input logic            start_ok,
    input float_t          cnt,
    input logic            cur_rd,
    input logic [CS_W-1:0] rd_cs,
    input float_t          float_sel
);

    p_idle_ok_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> start_ok);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt == '0));

    p_count_down_r9: assert property (@(posedge clk) disable iff (rst)
        (!(acc_end && cur_rd) && cnt != '0) |=> (cnt == FLOAT_W'($past(cnt) - 1'b1)));

    p_write_no_load_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_end && !cur_rd && cnt == '0) |=> (cnt == '0));

    p_float_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_end && cur_rd && float_sel == '0) |=> (cnt == '0));

    p_same_cs_read_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_write && req_cs == rd_cs) |-> start_ok);

    p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_end && cur_rd) |=> (!(req_valid && req_is_write) || !start_ok));

endmodule

bind bus_turnaround_gate bus_turnaround_gate_chk #(.CS_W(CS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_cs       (req_cs),
    .req_is_write (req_is_write),
    .acc_end      (acc_end),
    .start_ok     (start_ok),
    .cnt          (float_cnt),
    .cur_rd       (cur_is_read),
    .rd_cs        (last_rd_cs),
    .float_sel    (sel_float)
);

// File: tb/bus_turnaround_gate_bench.sv
module bus_turnaround_gate_bench;
    import bus_turnaround_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CS     = 8;
    localparam int CS_W       = 3;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req_valid = 1'b0;
    logic [CS_W-1:0]           req_cs = '0;
    logic                      req_is_write = 1'b0;
    logic                      acc_end = 1'b0;
    logic [NUM_CS*FLOAT_W-1:0] cfg_float;
    logic [NUM_CS-1:0]         cfg_opt_en;
    logic [NUM_CS*CYC_W-1:0]   cfg_rd_hold;
    logic [NUM_CS*CYC_W-1:0]   cfg_wr_setup;
    logic                      start_ok;

    int fl_c [NUM_CS]    = '{6, 10, 12, 0, 15, 5, 3, 3};
    int hold_c [NUM_CS]  = '{4, 2, 1, 3, 0, 9, 0, 0};
    int opt_c [NUM_CS]   = '{1, 0, 1, 0, 1, 0, 0, 0};
    int setup_c [NUM_CS] = '{3, 3, 4, 1, 15, 2, 2, 2};

    int checks = 0;
    int errors = 0;
    int stall  = 0;
    int exp_q [$];
    string tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_turnaround_gate #(.NUM_CS(NUM_CS)) u_bus_turnaround_gate (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_cs       (req_cs),
        .req_is_write (req_is_write),
        .acc_end      (acc_end),
        .cfg_float    (cfg_float),
        .cfg_opt_en   (cfg_opt_en),
        .cfg_rd_hold  (cfg_rd_hold),
        .cfg_wr_setup (cfg_wr_setup),
        .start_ok     (start_ok)
    );

    // Monitor: counts stall cycles and compares on each accepted start.
    always @(negedge clk) begin
        if (!rst && req_valid) begin
            if (start_ok) begin
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: start with no expected item, actual stall %0d expected none", stall);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (stall != e) begin
                        errors++;
                        $display("FAIL %s: stall cycles actual %0d expected %0d", t, stall, e);
                    end
                end
                stall = 0;
            end else begin
                stall++;
            end
        end
    end

    function automatic int sat(input int v);
        return (v > 0) ? v : 0;
    endfunction

    // Expected stall from the requirements.
    function automatic int expect_stall(input int ra, input int nb, input bit wr, input int g);
        int left;
        int credit;
        int fl;
        int turn;
        left   = sat(fl_c[ra] - hold_c[ra]);
        credit = (opt_c[ra] != 0 && wr) ? setup_c[nb] : 0;
        fl     = (!wr && ra == nb) ? 0 : sat(left - g - credit);
        turn   = (wr && g == 0) ? 1 : 0;
        return (fl > turn) ? fl : turn;
    endfunction

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic request(input int cs, input bit wr, input int e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_cs       = CS_W'(cs);
        req_is_write = wr;
        req_valid    = 1'b1;
        do @(negedge clk); while (!start_ok);
        @(posedge clk);
        #2;
        req_valid = 1'b0;
    endtask

    task automatic end_access();
        @(posedge clk);
        #2 acc_end = 1'b1;
        @(posedge clk);
        #2 acc_end = 1'b0;
    endtask

    task automatic pair(input int ra, input int nb, input bit wr, input int g, input string tag);
        idle(20);
        request(ra, 1'b0, 0, "R9 drained");
        idle(1);
        end_access();
        idle(g);
        request(nb, wr, expect_stall(ra, nb, wr, g), tag);
        idle(1);
        end_access();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_CS; i++) begin
            cfg_float[i*FLOAT_W +: FLOAT_W] = FLOAT_W'(fl_c[i]);
            cfg_opt_en[i]                   = (opt_c[i] != 0);
            cfg_rd_hold[i*CYC_W +: CYC_W]   = CYC_W'(hold_c[i]);
            cfg_wr_setup[i*CYC_W +: CYC_W]  = CYC_W'(setup_c[i]);
        end
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 / R11: idle output after reset, first request unstalled
        @(negedge clk);
        checks++;
        if (start_ok !== 1'b1) begin
            errors++;
            $display("FAIL R1: start_ok after reset actual %b expected 1", start_ok);
        end
        idle(1);
        request(1, 1'b1, 0, "R1 first write");
        idle(1);
        end_access();

        pair(1, 1, 1'b1, 0, "R3 opt off write same cs");
        pair(1, 2, 1'b0, 0, "R5 read other cs");
        pair(1, 1, 1'b0, 0, "R6 read same cs");
        pair(2, 2, 1'b1, 0, "R4 opt on partial credit");
        pair(2, 0, 1'b1, 0, "R12 credit from requested cs setup");
        pair(1, 2, 1'b1, 0, "R12 opt bit of reading cs");
        pair(0, 0, 1'b1, 0, "R7 turnaround when covered");
        pair(3, 1, 1'b0, 0, "R8 zero float");
        pair(5, 6, 1'b1, 0, "R2 hold covers float");
        pair(1, 0, 1'b1, 3, "R9 idle gap");
        pair(1, 2, 1'b0, 10, "R9 drained before request");
        pair(4, 4, 1'b1, 0, "R4 setup fully covers");
        pair(4, 7, 1'b0, 0, "R5 long float other cs");
        pair(2, 5, 1'b0, 1, "R2 hold one cycle");

        // R11: no request during float time keeps start_ok high
        idle(20);
        request(1, 1'b0, 0, "R9 drained");
        idle(1);
        end_access();
        @(negedge clk);
        checks++;
        if (start_ok !== 1'b1) begin
            errors++;
            $display("FAIL R11: start_ok without request actual %b expected 1", start_ok);
        end

        // R10: writes start no float period
        idle(20);
        request(1, 1'b1, 0, "R10 write");
        idle(1);
        end_access();
        request(2, 1'b1, 0, "R10 write after write");
        idle(1);
        end_access();
        request(3, 1'b0, 0, "R10 read after write");
        idle(3);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: pending items actual %0d expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule